// File: doc/BRIEF.md
# Dual-Mode Timer Peripheral

This block is a register-mapped timer with a level interrupt and a one-cycle trigger strobe. Software picks one of two counting schemes through a configuration register. In the first scheme the block counts down over a 32-bit period. The period is assembled from two 16-bit load halves, and the timer either stops after one expiry or reloads itself and keeps running. In the second scheme the block is a seconds counter that advances on an external one-cycle strobe and wraps back to zero once it would pass a 32-bit match value.

The load and match registers are each held as two 16-bit halves. When the configuration selects the split setting (value 4 or above), the upper half of a write to the low-timer address is dropped and reads of that address return only the lower half. Configuration values 2 and 3, and any split setting, are accepted and stored, but nothing counts in them. The mode, prescale and prescale-match registers of both sub-timers are plain storage. The interrupt is the OR of the raw status bits that are also allowed by the mask register.

Top module: `tmr_dual_mode`

## Requirements
- R1: After reset, every register reads 0 and both `irq` and `trig` are low.
- R2: With config 0, the write that sets control bit 0 (0 to 1) starts a countdown. Raw status bit 0 (address 0x1C) becomes 1 exactly P clocks after that write's edge, where P = {load high half, load low half}.
- R3: If bit 0 of the timer-A mode register (0x04) is 1, an expiry clears control bit 0 (0x0C) and no further expiry follows.
- R4: If bit 0 of the timer-A mode register is 0, the counter reloads on expiry and expires again every P clocks.
- R5: When control bit 5 is 1, `trig` is high for the one cycle in which raw status bit 0 is first seen set. When control bit 5 is 0, `trig` stays low.
- R6: With config 1 and control bit 0 set, each `sec_tick` strobe increments the seconds count, which reads back at 0x48. Strobes have no effect while control bit 0 is 0.
- R7: In seconds mode, if the incremented count would exceed the 32-bit match value (0x30), the count becomes 0. Raw status bit 3 is set whenever the count is 0 after a strobe.
- R8: The mask register (0x18) keeps only the bits in 0x77. `irq` is high exactly when raw AND mask is nonzero, and 0x20 reads raw AND mask.
- R9: Writing 0x24 clears each raw status bit that is 1 in the written value. A read of 0x24 returns 0.
- R10: A write to 0x28 or 0x30 always sets the low half from bits 15:0, and sets the high half from bits 31:16 only when config < 4. Reads of 0x28 and 0x30 join the halves under the same condition. Writes to 0x2C and 0x34 set the high half from bits 15:0, and reads of those addresses return the high half.
- R11: 0x48 reads 0 unless config is 1. 0x4C, unaligned and unmapped addresses read 0, and writes to them change nothing.
- R12: Rewriting control with bit 0 still 1 does not restart the countdown. Clearing bit 0 stops it, so no expiry occurs.
- R13: The mode (0x04, 0x08), prescale (0x38, 0x3C) and prescale-match (0x40, 0x44) registers read back the full value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 2*HALF_W | Write data |
| bus_rdata | output | 2*HALF_W | Read data for bus_addr (combinational) |
| sec_tick | input | 1 | One-cycle seconds strobe |
| irq | output | 1 | Level interrupt |
| trig | output | 1 | One-cycle expiry trigger |

## Verification
A countdown counter that is off by one moves the status bit by one clock, so the bench samples raw status both one cycle before and exactly at the expected expiry. A lost reload shows up within one period as a missing second expiry, and an unwanted restart shows up as an expiry that comes late. A wrong seconds count or a wrong wrap comparison shows up at the 0x48 readback right after the strobe that caused it. Mistakes in the half-register joining show up in the next read of 0x28, 0x2C, 0x30 or 0x34, or as a long period that expires far too early.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned OFS_CFG     = 'h00;
   localparam int unsigned OFS_MODE0   = 'h04;
   localparam int unsigned OFS_CTL     = 'h0C;
   localparam int unsigned OFS_MASK    = 'h18;
   localparam int unsigned OFS_RAW     = 'h1C;
   localparam int unsigned OFS_MIS     = 'h20;
   localparam int unsigned OFS_CLR     = 'h24;
   localparam int unsigned OFS_LOAD_LO = 'h28;
   localparam int unsigned OFS_LOAD_HI = 'h2C;
   localparam int unsigned OFS_MAT_LO  = 'h30;
   localparam int unsigned OFS_MAT_HI  = 'h34;
   localparam int unsigned OFS_PRE0    = 'h38;
   localparam int unsigned OFS_PMAT0   = 'h40;
   localparam int unsigned OFS_VAL     = 'h48;

   localparam int unsigned NUM_SUB     = 2;
   localparam int unsigned CFG_SPLIT   = 4;

   localparam int unsigned CTL_RUN     = 0;
   localparam int unsigned CTL_TRIG    = 5;
   localparam int unsigned ST_CNT      = 0;
   localparam int unsigned ST_RTC      = 3;
   localparam logic [7:0]  MASK_BITS   = 8'h77;

   typedef enum logic [1:0] {
      TM_CNT32 = 2'd0,
      TM_RTC32 = 2'd1,
      TM_SPLIT = 2'd2,
      TM_IDLE  = 2'd3
   } tmr_cfg_e;

   function automatic tmr_cfg_e cfg_decode(input logic [31:0] cfg);
      if (cfg == 32'd0)            return TM_CNT32;
      else if (cfg == 32'd1)       return TM_RTC32;
      else if (cfg >= CFG_SPLIT)   return TM_SPLIT;
      else                         return TM_IDLE;
   endfunction
endpackage

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             start,
   input  logic             oneshot,
   input  logic [CNT_W-1:0] period,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);
   assign expire  = run & ~start & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= period - 1'b1;
      end else if (run) begin
         if (!at_zero)      cnt_q <= cnt_q - 1'b1;
         else if (!oneshot) cnt_q <= period - 1'b1;
      end
   end

   // R4: a periodic expiry brings the period back into the counter
   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !oneshot) |=> (cnt_q == $past(period) - 1'b1));

   // R12: without run or start the counter holds its value
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_rtc.sv
module tmr_rtc #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] match,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] inc;
   logic [CNT_W-1:0] nxt;
   logic             step;

   assign step  = run & tick;
   assign inc   = cnt_q + 1'b1;
   assign nxt   = (inc > match) ? '0 : inc;
   assign wrap  = step & (nxt == '0);
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= nxt;
   end

   // R6: a strobe moves the count up by one or back to zero
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

   // R6: no strobe or no enable, no movement
   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && tick) |=> $stable(cnt_q));

   // R7: after a strobe the count never lies above the match value used
   a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> (cnt_q <= $past(match)));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [2*HALF_W-1:0]   bus_wdata,
   output logic [2*HALF_W-1:0]   bus_rdata,
   input  logic                  expire,
   input  logic                  wrap,
   input  logic [2*HALF_W-1:0]   rtc_count,
   output logic                  cnt_run,
   output logic                  cnt_start,
   output logic                  cnt_oneshot,
   output logic [2*HALF_W-1:0]   cnt_period,
   output logic                  rtc_run,
   output logic [2*HALF_W-1:0]   rtc_match,
   output logic                  trig_en,
   output logic                  irq
);
   localparam int unsigned DATA_W = 2 * HALF_W;
   localparam logic [DATA_W-1:0] KEEP = DATA_W'(MASK_BITS);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MIS  = ADDR_W'(OFS_MIS);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_LLO  = ADDR_W'(OFS_LOAD_LO);
   localparam logic [ADDR_W-1:0] A_LHI  = ADDR_W'(OFS_LOAD_HI);
   localparam logic [ADDR_W-1:0] A_MLO  = ADDR_W'(OFS_MAT_LO);
   localparam logic [ADDR_W-1:0] A_MHI  = ADDR_W'(OFS_MAT_HI);
   localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(OFS_VAL);

   logic [DATA_W-1:0] cfg_q, ctl_q, mask_q, raw_q, raw_d;
   logic [HALF_W-1:0] load_lo_q, load_hi_q, mat_lo_q, mat_hi_q;
   logic [NUM_SUB-1:0][DATA_W-1:0] mode_all, pre_all, pmat_all;
   tmr_cfg_e cfg_mode;
   logic     joined;
   logic     wr_cfg, wr_ctl, wr_mask, wr_clr, wr_llo, wr_lhi, wr_mlo, wr_mhi;

   assign cfg_mode = cfg_decode(32'(cfg_q));
   assign joined   = (cfg_q < DATA_W'(CFG_SPLIT));

   assign wr_cfg  = bus_wr & (bus_addr == A_CFG);
   assign wr_ctl  = bus_wr & (bus_addr == A_CTL);
   assign wr_mask = bus_wr & (bus_addr == A_MASK);
   assign wr_clr  = bus_wr & (bus_addr == A_CLR);
   assign wr_llo  = bus_wr & (bus_addr == A_LLO);
   assign wr_lhi  = bus_wr & (bus_addr == A_LHI);
   assign wr_mlo  = bus_wr & (bus_addr == A_MLO);
   assign wr_mhi  = bus_wr & (bus_addr == A_MHI);

   // per-sub-timer storage: mode, prescale, prescale-match
   for (genvar gi = 0; gi < NUM_SUB; gi++) begin : g_sub
      localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE0 + 4 * gi);
      localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(OFS_PRE0 + 4 * gi);
      localparam logic [ADDR_W-1:0] A_PMAT = ADDR_W'(OFS_PMAT0 + 4 * gi);
      logic [DATA_W-1:0] mode_q, pre_q, pmat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q <= '0;
            pre_q  <= '0;
            pmat_q <= '0;
         end else if (bus_wr) begin
            if (bus_addr == A_MODE) mode_q <= bus_wdata;
            if (bus_addr == A_PRE)  pre_q  <= bus_wdata;
            if (bus_addr == A_PMAT) pmat_q <= bus_wdata;
         end
      end
      assign mode_all[gi] = mode_q;
      assign pre_all[gi]  = pre_q;
      assign pmat_all[gi] = pmat_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         mask_q <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= bus_wdata;
         if (wr_mask) mask_q <= bus_wdata & KEEP;
      end
   end

   // control: software write wins over the one-shot self-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ctl_q <= '0;
      else if (wr_ctl)                 ctl_q <= bus_wdata;
      else if (expire && cnt_oneshot)  ctl_q[CTL_RUN] <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_lo_q <= '0;
         load_hi_q <= '0;
         mat_lo_q  <= '0;
         mat_hi_q  <= '0;
      end else begin
         if (wr_llo) load_lo_q <= bus_wdata[HALF_W-1:0];
         if (wr_mlo) mat_lo_q  <= bus_wdata[HALF_W-1:0];
         if (wr_lhi)              load_hi_q <= bus_wdata[HALF_W-1:0];
         else if (wr_llo && joined) load_hi_q <= bus_wdata[DATA_W-1:HALF_W];
         if (wr_mhi)              mat_hi_q <= bus_wdata[HALF_W-1:0];
         else if (wr_mlo && joined) mat_hi_q <= bus_wdata[DATA_W-1:HALF_W];
      end
   end

   // status: new events take priority over a clear in the same cycle
   always_comb begin
      raw_d = raw_q;
      if (wr_clr) raw_d = raw_q & ~bus_wdata;
      if (expire) raw_d[ST_CNT] = 1'b1;
      if (wrap)   raw_d[ST_RTC] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= raw_d;
   end

   assign irq         = |(raw_q & mask_q);
   assign cnt_start   = wr_ctl & bus_wdata[CTL_RUN] & ~ctl_q[CTL_RUN];
   assign cnt_run     = ctl_q[CTL_RUN] & (cfg_mode == TM_CNT32);
   assign rtc_run     = ctl_q[CTL_RUN] & (cfg_mode == TM_RTC32);
   assign cnt_oneshot = mode_all[0][0];
   assign cnt_period  = {load_hi_q, load_lo_q};
   assign rtc_match   = {mat_hi_q, mat_lo_q};
   assign trig_en     = ctl_q[CTL_TRIG];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CFG:  bus_rdata = cfg_q;
         A_CTL:  bus_rdata = ctl_q;
         A_MASK: bus_rdata = mask_q;
         A_RAW:  bus_rdata = raw_q;
         A_MIS:  bus_rdata = raw_q & mask_q;
         A_LLO:  bus_rdata = joined ? {load_hi_q, load_lo_q} : {{HALF_W{1'b0}}, load_lo_q};
         A_LHI:  bus_rdata = {{HALF_W{1'b0}}, load_hi_q};
         A_MLO:  bus_rdata = joined ? {mat_hi_q, mat_lo_q} : {{HALF_W{1'b0}}, mat_lo_q};
         A_MHI:  bus_rdata = {{HALF_W{1'b0}}, mat_hi_q};
         A_VAL:  bus_rdata = (cfg_mode == TM_RTC32) ? rtc_count : '0;
         default: bus_rdata = '0;
      endcase
      for (int i = 0; i < NUM_SUB; i++) begin
         if (bus_addr == ADDR_W'(OFS_MODE0 + 4 * i)) bus_rdata = mode_all[i];
         if (bus_addr == ADDR_W'(OFS_PRE0 + 4 * i))  bus_rdata = pre_all[i];
         if (bus_addr == ADDR_W'(OFS_PMAT0 + 4 * i)) bus_rdata = pmat_all[i];
      end
   end

   // R3: a one-shot expiry drops the enable unless software writes control
   a_r3_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && cnt_oneshot && !wr_ctl) |=> !ctl_q[CTL_RUN]);

   // R2: an expiry is always recorded in raw status
   a_r2_status_set: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> raw_q[ST_CNT]);

   // R8: the mask never holds bits outside the kept set
   a_r8_mask_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q & ~KEEP) == '0);

   // R9: a clear with no concurrent expiry empties bit 0
   a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && bus_wdata[ST_CNT] && !expire) |=> !raw_q[ST_CNT]);

   // R12: writing the enable low stops the countdown next cycle
   a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !bus_wdata[CTL_RUN]) |=> !cnt_run);
endmodule

// File: rtl/tmr_dual_mode.sv
module tmr_dual_mode
   import tmr_pkg::*;
#(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [2*HALF_W-1:0] bus_wdata,
   output logic [2*HALF_W-1:0] bus_rdata,
   input  logic                sec_tick,
   output logic                irq,
   output logic                trig
);
   localparam int unsigned DATA_W = 2 * HALF_W;

   if (HALF_W < 8) begin : g_chk_half
      $error("tmr_dual_mode: HALF_W must be at least 8");
   end
   if (ADDR_W < 7) begin : g_chk_addr
      $error("tmr_dual_mode: ADDR_W too narrow for the register map");
   end

   logic              expire, wrap;
   logic              cnt_run, cnt_start, cnt_oneshot, rtc_run, trig_en;
   logic [DATA_W-1:0] cnt_period, rtc_match, rtc_count;
   logic              trig_q;

   tmr_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .expire(expire), .wrap(wrap), .rtc_count(rtc_count),
      .cnt_run(cnt_run), .cnt_start(cnt_start), .cnt_oneshot(cnt_oneshot),
      .cnt_period(cnt_period), .rtc_run(rtc_run), .rtc_match(rtc_match),
      .trig_en(trig_en), .irq(irq)
   );

   tmr_countdown #(.CNT_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(cnt_run), .start(cnt_start),
      .oneshot(cnt_oneshot), .period(cnt_period), .expire(expire)
   );

   tmr_rtc #(.CNT_W(DATA_W)) u_rtc (
      .clk(clk), .rst_n(rst_n), .run(rtc_run), .tick(sec_tick),
      .match(rtc_match), .count(rtc_count), .wrap(wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= expire & trig_en;
   end
   assign trig = trig_q;

   // R5: an enabled expiry produces the trigger strobe
   a_r5_trig_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && trig_en) |=> trig);

   // R5: no expiry or trigger disabled, no strobe
   a_r5_trig_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(expire && trig_en) |=> !trig);
endmodule

// File: tb/tmr_dual_mode_tb.sv
module tmr_dual_mode_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sec_tick = 1'b0;
   logic        irq, trig;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q[$];
   event smp_ev;

   always #10 clk = ~clk;

   tmr_dual_mode u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
      .irq(irq), .trig(trig)
   );

   // monitor: pops expected items and compares against the outputs
   always @(smp_ev) begin
      while (sb_q.size() > 0) begin
         sb_item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         case (it.kind)
            0: act = bus_rdata;
            1: act = {31'd0, irq};
            default: act = {31'd0, trig};
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
         end
      end
   end

   task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      bus_addr = a;
      #1;
      sb_q.push_back('{0, e, tag});
      -> smp_ev;
      #1;
   endtask

   task automatic exp_pin(input int k, input logic e, input string tag);
      #1;
      sb_q.push_back('{k, {31'd0, e}, tag});
      -> smp_ev;
      #1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a;
      bus_wdata = d;
      bus_wr = 1'b1;
      @(posedge clk);
      #2;
      bus_wr = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic tick1();
      sec_tick = 1'b1;
      @(posedge clk);
      #2;
      sec_tick = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all R) actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      exp_rd(12'h000, 32'h0, "R1 cfg");
      exp_rd(12'h00C, 32'h0, "R1 ctl");
      exp_rd(12'h01C, 32'h0, "R1 raw");
      exp_rd(12'h028, 32'h0, "R1 load");
      exp_rd(12'h018, 32'h0, "R1 mask");
      exp_pin(1, 1'b0, "R1 irq");
      exp_pin(2, 1'b0, "R1 trig");

      // R13 storage registers
      wr(12'h008, 32'hA5A5_00A5);
      wr(12'h03C, 32'h0000_0077);
      wr(12'h040, 32'h1234_5678);
      exp_rd(12'h008, 32'hA5A5_00A5, "R13 mode B");
      exp_rd(12'h03C, 32'h0000_0077, "R13 prescale B");
      exp_rd(12'h040, 32'h1234_5678, "R13 prescale-match A");

      // R8 mask keeps 0x77 only
      wr(12'h018, 32'hFFFF_FFFF);
      exp_rd(12'h018, 32'h0000_0077, "R8 mask trim");

      // R2/R3/R5 one-shot with trigger, period 5
      wr(12'h004, 32'h1);
      wr(12'h028, 32'h5);
      wr(12'h00C, 32'h21);
      step(4);
      exp_rd(12'h01C, 32'h0, "R2 no early expiry");
      exp_pin(2, 1'b0, "R5 trig idle before expiry");
      step(1);
      exp_rd(12'h01C, 32'h1, "R2 expiry at P");
      exp_pin(2, 1'b1, "R5 trig pulse");
      exp_pin(1, 1'b1, "R8 irq on masked status");
      exp_rd(12'h020, 32'h1, "R8 masked status");
      exp_rd(12'h00C, 32'h20, "R3 enable cleared");
      step(1);
      exp_pin(2, 1'b0, "R5 trig one cycle");

      // R9 write-one-to-clear
      wr(12'h024, 32'h1);
      exp_rd(12'h01C, 32'h0, "R9 cleared");
      exp_pin(1, 1'b0, "R8 irq drops");
      exp_rd(12'h024, 32'h0, "R9 clear reads 0");
      step(10);
      exp_rd(12'h01C, 32'h0, "R3 no second expiry");

      // R4 periodic, period 4, no trigger
      wr(12'h004, 32'h2);
      wr(12'h028, 32'h4);
      wr(12'h00C, 32'h1);
      step(3);
      exp_rd(12'h01C, 32'h0, "R4 before first expiry");
      step(1);
      exp_rd(12'h01C, 32'h1, "R4 first expiry");
      exp_pin(2, 1'b0, "R5 no trig when bit5 clear");
      wr(12'h024, 32'h1);
      step(2);
      exp_rd(12'h01C, 32'h0, "R4 between expiries");
      step(1);
      exp_rd(12'h01C, 32'h1, "R4 second expiry");

      // R12 stop and no restart on rewrite
      wr(12'h00C, 32'h0);
      wr(12'h024, 32'h1);
      step(8);
      exp_rd(12'h01C, 32'h0, "R12 stopped");
      wr(12'h00C, 32'h1);
      wr(12'h00C, 32'h1);
      step(2);
      exp_rd(12'h01C, 32'h0, "R12 not yet expired");
      step(1);
      exp_rd(12'h01C, 32'h1, "R12 rewrite did not restart");
      wr(12'h00C, 32'h0);

      // R2 long period using the high half, one-shot
      wr(12'h004, 32'h1);
      wr(12'h028, 32'h0001_0002);
      wr(12'h024, 32'hFF);
      wr(12'h00C, 32'h1);
      step(65537);
      exp_rd(12'h01C, 32'h0, "R2 high half no early expiry");
      step(1);
      exp_rd(12'h01C, 32'h1, "R2 high half expiry");

      // R10 half joining
      wr(12'h000, 32'h4);
      wr(12'h028, 32'hAAAA_5555);
      exp_rd(12'h028, 32'h0000_5555, "R10 split low read");
      exp_rd(12'h02C, 32'h0000_0001, "R10 high kept in split");
      wr(12'h02C, 32'h0000_1234);
      wr(12'h000, 32'h0);
      exp_rd(12'h028, 32'h1234_5555, "R10 joined read");
      wr(12'h030, 32'hDEAD_BEEF);
      exp_rd(12'h030, 32'hDEAD_BEEF, "R10 match joined");
      exp_rd(12'h034, 32'h0000_DEAD, "R10 match high");
      wr(12'h000, 32'h4);
      wr(12'h030, 32'h7777_0011);
      exp_rd(12'h030, 32'h0000_0011, "R10 match split");
      exp_rd(12'h034, 32'h0000_DEAD, "R10 match high kept");

      // R11 unmapped and value reads
      wr(12'h000, 32'h0);
      exp_rd(12'h048, 32'h0, "R11 value outside seconds mode");
      exp_rd(12'h04C, 32'h0, "R11 timer B value");
      wr(12'h080, 32'hFFFF_FFFF);
      exp_rd(12'h080, 32'h0, "R11 unmapped");
      exp_rd(12'h000, 32'h0, "R11 unmapped write ignored");

      // R6/R7 seconds counter, match 2
      wr(12'h000, 32'h1);
      wr(12'h030, 32'h0000_0002);
      wr(12'h024, 32'hFF);
      tick1();
      exp_rd(12'h048, 32'h0, "R6 tick ignored when disabled");
      wr(12'h00C, 32'h1);
      tick1();
      exp_rd(12'h048, 32'h1, "R6 count 1");
      tick1();
      exp_rd(12'h048, 32'h2, "R6 count 2");
      exp_rd(12'h01C, 32'h0, "R7 no wrap yet");
      tick1();
      exp_rd(12'h048, 32'h0, "R7 wrap past match");
      exp_rd(12'h01C, 32'h8, "R7 wrap status");
      exp_pin(1, 1'b0, "R8 bit3 not maskable");
      step(3);
      exp_rd(12'h048, 32'h0, "R6 no tick no change");
      tick1();
      exp_rd(12'h048, 32'h1, "R6 count after wrap");
      wr(12'h024, 32'h8);
      exp_rd(12'h01C, 32'h0, "R9 clear bit3");
      wr(12'h000, 32'h4);
      exp_rd(12'h048, 32'h0, "R11 value hidden in split");

      step(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule